// File: doc/BRIEF.md
# Address Burst Legality Monitor

This block watches one address-request channel of a memory-mapped burst bus, either the write or the read side, and judges every request that is presented while `req_valid_i` is high. From the start address, the beat size code, the beat count code and the burst type it works out where the final beat of the burst lands. It reports an incrementing burst whose final beat falls in a different 4 KiB page from its first beat. When the request asks for exclusive access, it also checks the rules that such a request must meet: a power-of-two byte total, a bounded beat count and natural alignment. Each rule has its own one-cycle error pulse, and a sticky register collects every rule that has fired since it was last cleared.

To cover both channels, a chip places one instance on each of them. The monitor never drives the bus. It evaluates its inputs combinationally and registers all of its outputs, so every verdict appears one clock after the cycle that was judged. A request that is held stalled is judged again in every cycle it stays valid.

Top module: `burst_legality_mon`

## Requirements
- R1: When `req_valid_i` is high and `req_burst_i` is 1 (incrementing), `err_page_o` is high in the next cycle exactly when the page number (address bits 12 and up, including any carry beyond the top address bit) of the start address differs from that of the final beat address.
- R2: Bursts of type 0 (fixed), 2 (wrapping) and 3 (reserved) never raise `err_page_o`, whatever their address and length.
- R3: The final beat address is the start address rounded down to a multiple of 2^`req_size_i`, plus `req_len_i`·2^`req_size_i`. Beat 0 keeps the unaligned start address. The burst has `req_len_i`+1 beats.
- R4: `err_size_o` is high in the next cycle when a valid request has `req_size_i` greater than log2(DATA_BYTES) (3 by default), whether or not it is exclusive.
- R5: For a valid request with `req_lock_i` high, `err_xbytes_o` is high in the next cycle when the byte total (`req_len_i`+1)·2^`req_size_i` is not a power of two or is above 128.
- R6: For a valid request with `req_lock_i` high, `err_xbeats_o` is high in the next cycle when the burst has more than 16 beats (`req_len_i` > 15).
- R7: For a valid request with `req_lock_i` high and a legal byte total (as in R5), `err_xalign_o` is high in the next cycle when the start address is not a multiple of the byte total. If the byte total is illegal, no alignment error is reported.
- R8: A request with `req_lock_i` low never raises `err_xbytes_o`, `err_xbeats_o` or `err_xalign_o`.
- R9: No error pulse follows a cycle with `req_valid_i` low. A violating request held valid for several cycles raises its pulse in each following cycle.
- R10: `err_sticky_o` collects pulses with bit 0 = page, 1 = size, 2 = byte total, 3 = beat count, 4 = alignment. A bit stays set until `sticky_clr_i`. A clear removes the old contents, but a violation judged in the same cycle as the clear is still recorded.
- R11: `viol_taken_o` is high in the cycle after one in which `req_valid_i` and `req_ready_i` are both high and at least one rule is broken.
- R12: While reset is active and in the first cycle after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present on the address channel |
| req_ready_i | input | 1 | Receiver accepts the request |
| req_addr_i | input | ADDR_W (32) | Start byte address |
| req_size_i | input | 3 | log2 of bytes per beat |
| req_len_i | input | 8 | Beat count minus one |
| req_burst_i | input | 2 | Burst type: 0 fixed, 1 incrementing, 2 wrapping |
| req_lock_i | input | 1 | Exclusive-access request |
| sticky_clr_i | input | 1 | Clears the sticky error register |
| err_page_o | output | 1 | Page-crossing pulse |
| err_size_o | output | 1 | Oversized beat pulse |
| err_xbytes_o | output | 1 | Exclusive byte-total pulse |
| err_xbeats_o | output | 1 | Exclusive beat-count pulse |
| err_xalign_o | output | 1 | Exclusive alignment pulse |
| err_sticky_o | output | 5 | Accumulated rule violations |
| viol_taken_o | output | 1 | A violating request was accepted |

## Verification
The hardest case to reach is the page test at its exact boundary. An unaligned start with a wide beat lands one byte short of a page edge or just past it, and only the rounding-down of R3 decides the verdict. Purely random addresses almost never fall there. The stimulus therefore uses directed requests just below 0x1000 and at the very top of the address space, then random requests whose offsets are forced into the last 256 bytes of a page, with exclusive requests mixed in so that the alignment rule sees both legal and illegal byte totals.

// File: rtl/burst_legality_pkg.sv
package burst_legality_pkg;

    typedef enum logic [1:0] {
        BT_FIXED = 2'd0,
        BT_INCR  = 2'd1,
        BT_WRAP  = 2'd2,
        BT_RSVD  = 2'd3
    } burst_kind_e;

    localparam int unsigned N_RULES = 5;

    typedef enum int unsigned {
        RULE_PAGE   = 0,
        RULE_SIZE   = 1,
        RULE_XBYTES = 2,
        RULE_XBEATS = 3,
        RULE_XALIGN = 4
    } rule_idx_e;

    typedef logic [N_RULES-1:0] rule_vec_t;

endpackage

// File: rtl/burst_span_calc.sv
module burst_span_calc #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LEN_W     = 8,
    parameter int unsigned SIZE_W    = 3,
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [1:0]        burst_i,
    output logic              crosses_o
);
    import burst_legality_pkg::*;

    localparam int unsigned EXT_W  = ADDR_W + 1;
    localparam int unsigned PAGE_W = EXT_W - PAGE_BITS;

    logic [ADDR_W-1:0] lane_mask;
    logic [ADDR_W-1:0] aligned_start;
    logic [EXT_W-1:0]  span_off;
    logic [EXT_W-1:0]  last_beat;
    logic [EXT_W-1:0]  first_beat;
    logic [PAGE_W-1:0] first_page;
    logic [PAGE_W-1:0] last_page;

    always_comb begin
        lane_mask     = ~(({ADDR_W{1'b1}}) << size_i);
        aligned_start = start_addr_i & ~lane_mask;
        span_off      = EXT_W'(len_i) << size_i;
        first_beat    = {1'b0, start_addr_i};
        last_beat     = {1'b0, aligned_start} + span_off;
        first_page    = first_beat[EXT_W-1:PAGE_BITS];
        last_page     = last_beat[EXT_W-1:PAGE_BITS];
        crosses_o     = (burst_kind_e'(burst_i) == BT_INCR) && (first_page != last_page);
    end

endmodule

// File: rtl/excl_rule_eval.sv
module excl_rule_eval #(
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned LEN_W          = 8,
    parameter int unsigned SIZE_W         = 3,
    parameter int unsigned EXCL_MAX_BYTES = 128,
    parameter int unsigned EXCL_MAX_BEATS = 16
) (
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              lock_i,
    output logic              bad_bytes_o,
    output logic              bad_beats_o,
    output logic              bad_align_o
);
    localparam int unsigned BEATS_W = LEN_W + 1;
    localparam int unsigned TOT_W   = BEATS_W + (1 << SIZE_W) - 1;
    localparam int unsigned CMP_W   = (TOT_W > ADDR_W) ? TOT_W : ADDR_W;

    logic [BEATS_W-1:0] beats;
    logic [TOT_W-1:0]   total;
    logic               beats_pow2;
    logic               total_small;
    logic               total_ok;
    logic [CMP_W-1:0]   low_mask;
    logic [CMP_W-1:0]   addr_ext;

    always_comb begin
        beats       = BEATS_W'(len_i) + BEATS_W'(1);
        total       = TOT_W'(beats) << size_i;
        beats_pow2  = ((beats & (beats - BEATS_W'(1))) == '0);
        total_small = (32'(total) <= EXCL_MAX_BYTES);
        total_ok    = beats_pow2 && total_small;
        low_mask    = CMP_W'(total) - CMP_W'(1);
        addr_ext    = CMP_W'(start_addr_i);
        bad_bytes_o = lock_i && !total_ok;
        bad_beats_o = lock_i && (32'(beats) > EXCL_MAX_BEATS);
        bad_align_o = lock_i && total_ok && ((addr_ext & low_mask) != '0);
    end

endmodule

// File: rtl/burst_legality_mon.sv
module burst_legality_mon #(
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned LEN_W          = 8,
    parameter int unsigned SIZE_W         = 3,
    parameter int unsigned DATA_BYTES     = 8,
    parameter int unsigned PAGE_BITS      = 12,
    parameter int unsigned EXCL_MAX_BYTES = 128,
    parameter int unsigned EXCL_MAX_BEATS = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_ready_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [2:0]        req_size_i,
    input  logic [7:0]        req_len_i,
    input  logic [1:0]        req_burst_i,
    input  logic              req_lock_i,
    input  logic              sticky_clr_i,
    output logic              err_page_o,
    output logic              err_size_o,
    output logic              err_xbytes_o,
    output logic              err_xbeats_o,
    output logic              err_xalign_o,
    output logic [4:0]        err_sticky_o,
    output logic              viol_taken_o
);
    import burst_legality_pkg::*;

    localparam int unsigned MAX_SIZE = $clog2(DATA_BYTES);

    typedef struct packed {
        rule_vec_t pulse;
        rule_vec_t sticky;
        logic      taken;
    } mon_state_t;

    logic [SIZE_W-1:0] size_n;
    logic [LEN_W-1:0]  len_n;
    logic              page_hit;
    logic              xbytes_hit;
    logic              xbeats_hit;
    logic              xalign_hit;
    rule_vec_t         raw_hits;
    rule_vec_t         judged;
    mon_state_t        st_d;
    mon_state_t        st_q;

    assign size_n = SIZE_W'(req_size_i);
    assign len_n  = LEN_W'(req_len_i);

    burst_span_calc #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .SIZE_W    (SIZE_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_span (
        .start_addr_i (req_addr_i),
        .size_i       (size_n),
        .len_i        (len_n),
        .burst_i      (req_burst_i),
        .crosses_o    (page_hit)
    );

    excl_rule_eval #(
        .ADDR_W         (ADDR_W),
        .LEN_W          (LEN_W),
        .SIZE_W         (SIZE_W),
        .EXCL_MAX_BYTES (EXCL_MAX_BYTES),
        .EXCL_MAX_BEATS (EXCL_MAX_BEATS)
    ) u_excl (
        .start_addr_i (req_addr_i),
        .size_i       (size_n),
        .len_i        (len_n),
        .lock_i       (req_lock_i),
        .bad_bytes_o  (xbytes_hit),
        .bad_beats_o  (xbeats_hit),
        .bad_align_o  (xalign_hit)
    );

    always_comb begin
        raw_hits              = '0;
        raw_hits[RULE_PAGE]   = page_hit;
        raw_hits[RULE_SIZE]   = (32'(size_n) > MAX_SIZE);
        raw_hits[RULE_XBYTES] = xbytes_hit;
        raw_hits[RULE_XBEATS] = xbeats_hit;
        raw_hits[RULE_XALIGN] = xalign_hit;
    end

    for (genvar g = 0; g < N_RULES; g++) begin : g_rule
        always_comb begin
            judged[g]    = req_valid_i && raw_hits[g];
            st_d.pulse[g] = judged[g];
            st_d.sticky[g] = (sticky_clr_i ? 1'b0 : st_q.sticky[g]) | judged[g];
        end
    end

    always_comb begin
        st_d.taken = req_valid_i && req_ready_i && (|raw_hits);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_page_o   = st_q.pulse[RULE_PAGE];
    assign err_size_o   = st_q.pulse[RULE_SIZE];
    assign err_xbytes_o = st_q.pulse[RULE_XBYTES];
    assign err_xbeats_o = st_q.pulse[RULE_XBEATS];
    assign err_xalign_o = st_q.pulse[RULE_XALIGN];
    assign err_sticky_o = st_q.sticky;
    assign viol_taken_o = st_q.taken;

endmodule

module burst_legality_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_valid_i,
    input logic       req_ready_i,
    input logic [1:0] req_burst_i,
    input logic       req_lock_i,
    input logic       sticky_clr_i,
    input logic       err_page_o,
    input logic       err_size_o,
    input logic       err_xbytes_o,
    input logic       err_xbeats_o,
    input logic       err_xalign_o,
    input logic [4:0] err_sticky_o,
    input logic       viol_taken_o
);
    logic [4:0] pulses;
    assign pulses = {err_xalign_o, err_xbeats_o, err_xbytes_o, err_size_o, err_page_o};

    p_exempt_burst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_burst_i != 2'd1) |=> !err_page_o);

    p_no_lock_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_lock_i) |=> !(err_xbytes_o || err_xbeats_o || err_xalign_o));

    p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (pulses == 5'd0) && !viol_taken_o);

    p_pulse_recorded_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pulses != 5'd0) |-> ((err_sticky_o & pulses) == pulses));

    p_sticky_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sticky_clr_i |=> ((err_sticky_o & $past(err_sticky_o)) == $past(err_sticky_o)));

    p_clear_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sticky_clr_i && !req_valid_i) |=> (err_sticky_o == 5'd0));

    p_stall_not_taken_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_ready_i) |=> !viol_taken_o);

    p_taken_has_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_taken_o |-> (pulses != 5'd0));
endmodule

bind burst_legality_mon burst_legality_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_i  (req_ready_i),
    .req_burst_i  (req_burst_i),
    .req_lock_i   (req_lock_i),
    .sticky_clr_i (sticky_clr_i),
    .err_page_o   (err_page_o),
    .err_size_o   (err_size_o),
    .err_xbytes_o (err_xbytes_o),
    .err_xbeats_o (err_xbeats_o),
    .err_xalign_o (err_xalign_o),
    .err_sticky_o (err_sticky_o),
    .viol_taken_o (viol_taken_o)
);

// File: tb/burst_legality_mon_tb.sv
module burst_legality_mon_tb;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [2:0]  req_size_i = '0;
    logic [7:0]  req_len_i = '0;
    logic [1:0]  req_burst_i = '0;
    logic        req_lock_i = 1'b0;
    logic        sticky_clr_i = 1'b0;
    logic        err_page_o, err_size_o, err_xbytes_o, err_xbeats_o, err_xalign_o;
    logic [4:0]  err_sticky_o;
    logic        viol_taken_o;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic [4:0] exp_pulse = '0;
    logic [4:0] exp_sticky = '0;
    logic       exp_taken = 1'b0;

    always #2.5 clk_i = ~clk_i;

    burst_legality_mon u_dut (
        .clk_i, .rst_ni, .req_valid_i, .req_ready_i, .req_addr_i, .req_size_i,
        .req_len_i, .req_burst_i, .req_lock_i, .sticky_clr_i,
        .err_page_o, .err_size_o, .err_xbytes_o, .err_xbeats_o, .err_xalign_o,
        .err_sticky_o, .viol_taken_o
    );

    function automatic logic [4:0] model_rules(logic [31:0] a, int sz, int ln, int bt, logic lk);
        logic [4:0] r = '0;
        longint unsigned al, last, tot, beats;
        al    = (longint'(a) >> sz) << sz;
        last  = al + (longint'(ln) << sz);
        beats = ln + 1;
        tot   = beats << sz;
        if (bt == 1 && (longint'(a) >> 12) != (last >> 12)) r[0] = 1'b1; // R1 R3
        if (sz > 3) r[1] = 1'b1;                                         // R4
        if (lk) begin
            if ((beats & (beats - 1)) != 0 || tot > 128) r[2] = 1'b1;   // R5
            if (beats > 16) r[3] = 1'b1;                                 // R6
            if (!r[2] && (longint'(a) % tot) != 0) r[4] = 1'b1;          // R7
        end
        return r;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 page pulse", err_page_o, exp_pulse[0]);
        chk("R4 size pulse", err_size_o, exp_pulse[1]);
        chk("R5 xbytes pulse", err_xbytes_o, exp_pulse[2]);
        chk("R6 xbeats pulse", err_xbeats_o, exp_pulse[3]);
        chk("R7 xalign pulse", err_xalign_o, exp_pulse[4]);
        chk("R10 sticky", err_sticky_o, exp_sticky);
        chk("R11 taken", viol_taken_o, exp_taken);
    endtask

    // drive at negedge after comparing the previous verdict
    task automatic step(logic v, logic rd, logic [31:0] a, int sz, int ln, int bt, logic lk, logic clr);
        logic [4:0] r;
        @(negedge clk_i);
        compare_all();
        req_valid_i = v; req_ready_i = rd; req_addr_i = a; req_size_i = 3'(sz);
        req_len_i = 8'(ln); req_burst_i = 2'(bt); req_lock_i = lk; sticky_clr_i = clr;
        r = v ? model_rules(a, sz, ln, bt, lk) : 5'd0;
        exp_pulse  = r;
        exp_sticky = (clr ? 5'd0 : exp_sticky) | r;
        exp_taken  = v && rd && (r != 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R12: outputs zero during reset
        repeat (3) @(negedge clk_i);
        chk("R12 reset sticky", err_sticky_o, 0);
        chk("R12 reset pulses", {err_page_o, err_size_o, err_xbytes_o, err_xbeats_o, err_xalign_o, viol_taken_o}, 0);
        rst_ni = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // R1 R3: boundary cases
        step(1, 1, 32'h0000_0FF8, 3, 0, 1, 0, 0); // fits
        step(1, 1, 32'h0000_0FF8, 3, 1, 1, 0, 0); // crosses
        step(1, 1, 32'h0000_0FFD, 2, 0, 1, 0, 0); // R3 unaligned, no cross
        step(1, 1, 32'h0000_0FFD, 2, 1, 1, 0, 0); // R3 last beat 0x1000
        step(1, 1, 32'h0000_0F01, 3, 30, 1, 0, 0); // R3 aligned 0xF00+0xF0 fits
        step(1, 1, 32'hFFFF_FFF0, 3, 3, 1, 0, 0); // top-of-space carry
        // R2: exempt burst types
        step(1, 1, 32'h0000_0FF8, 3, 255, 0, 0, 0);
        step(1, 1, 32'h0000_0FF8, 3, 255, 2, 0, 0);
        step(1, 1, 32'h0000_0FF8, 3, 255, 3, 0, 1);
        // R4 size
        step(1, 0, 32'h0000_0000, 4, 0, 1, 0, 0);
        step(1, 0, 32'h0000_0000, 7, 0, 0, 0, 0);
        // R5 R6 R7 exclusive
        step(1, 1, 32'h0000_0040, 3, 2, 1, 1, 1); // 24 bytes
        step(1, 1, 32'h0000_0040, 3, 31, 1, 1, 0); // 256 bytes, 32 beats
        step(1, 1, 32'h0000_0040, 0, 31, 1, 1, 0); // 32 beats of 1 byte
        step(1, 1, 32'h0000_0048, 3, 15, 1, 1, 0); // 128 B misaligned
        step(1, 1, 32'h0000_0080, 3, 15, 1, 1, 0); // legal
        step(1, 1, 32'h0000_0001, 0, 0, 1, 1, 0); // 1 byte legal
        step(1, 1, 32'h0000_0048, 3, 15, 1, 0, 0); // R8 not locked
        // R9 stall repeated, then idle
        step(1, 0, 32'h0000_0FFC, 2, 3, 1, 0, 1);
        step(1, 0, 32'h0000_0FFC, 2, 3, 1, 0, 0);
        step(1, 1, 32'h0000_0FFC, 2, 3, 1, 0, 0);
        step(0, 1, 32'h0000_0FFC, 2, 3, 1, 1, 0);
        // R10 clear with simultaneous violation, then clear idle
        step(1, 1, 32'h0000_0004, 5, 0, 1, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // random, offsets near page end
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            a = {$urandom(), 12'h000} | 32'(12'hF00 | ($urandom() & 8'hFF));
            if (($urandom() % 4) == 0) a = a & ~32'hFF;
            step($urandom() % 5 != 0, $urandom() % 2, a, $urandom() % 8,
                 ($urandom() % 3 == 0) ? $urandom() % 256 : $urandom() % 20,
                 $urandom() % 4, $urandom() % 3 == 0, $urandom() % 16 == 0);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk_i);
        compare_all();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule